// File: doc/BRIEF.md
# Dual-channel alternating current-mode PWM controller

This block is a digital controller for two interleaved PWM outputs that share one timebase. A free-running counter forms the oscillator ramp. Each oscillator cycle has a charge phase of `RAMP_LEN` clock cycles followed by a discharge phase of `DISCH_LEN` cycles. A slot bit flips at every cycle boundary and hands successive oscillator cycles to channel 1 and channel 2 in turn. Each output therefore switches at half the oscillator rate and can never be high for half of its own period.

A channel raises its output in the first cycle of its own slot. It drops the output when the ramp reaches the duty command captured at the slot start, when the charge phase ends, or when its current-sense trip flag is seen after the blanking window. A separate overcurrent flag on either channel starts a full-cycle fault restart. The comparators, error amplifiers, supply lockout and gate drivers sit outside the block and deliver their results as synchronous digital inputs. An external sync input, once it is filtered for width, restarts the ramp. Channel 2 can be held off with an active-high enable; tie that enable high when it is not used.

Top module: `dual_pwm_ctrl`

## Requirements
- R1: The oscillator cycle lasts `RAMP_LEN+DISCH_LEN` clock cycles. Slots alternate at every cycle boundary, channel 1 and then channel 2. `pwm_out[0]` belongs to channel 1 and can be high only in channel 1 slots; `pwm_out[1]` belongs to channel 2 and can be high only in channel 2 slots.
- R2: A channel's output is high from the first cycle of its slot for exactly as many cycles as its duty command. The command is captured at the slot boundary, so a change during the slot has no effect until that channel's next slot.
- R3: On-time never exceeds `RAMP_LEN` cycles. A duty command of `RAMP_LEN` or more gives exactly `RAMP_LEN` cycles.
- R4: In the last `DISCH_LEN` cycles of every oscillator cycle both outputs are low.
- R5: A duty command of 0 keeps the output low for its whole slot.
- R6: A channel's `trip_in` bit is sampled high in cycle k of a high pulse, where k counts from 0 at the rising edge and k >= `BLANK_CYC`. The output is then low from cycle k+1 to the end of the slot.
- R7: A `trip_in` bit that is high during cycles 0 to `BLANK_CYC-1` of a pulse is ignored, and the pulse keeps its full length.
- R8: If `ch2_en` is low at a channel 2 slot boundary, channel 2 stays low for that slot. Channel 1 and the slot alternation are unaffected.
- R9: `sync_in` passes through a two-flop synchronizer. Once it has been high for `SYNC_MIN` consecutive sampled cycles, the current oscillator cycle ends and a new one begins in the other channel's slot. With the defaults, a pulse first sampled at the edge that ends cycle s gives a slot that is s+4 cycles long. Shorter pulses are ignored, and a pulse held high causes only one restart.
- R10: If any `ovc_in` bit is sampled high, both outputs are low from the next cycle. They stay off until a channel 1 slot begins with no overcurrent sampled at that boundary. An overcurrent in the last cycle before a channel 1 slot therefore blanks that whole slot and the channel 2 slot after it.
- R11: Both outputs are low while `rst` is high. The first channel 1 slot starts in the first cycle after `rst` falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sync_in | input | 1 | Asynchronous oscillator restart request |
| ch2_en | input | 1 | Channel 2 enable, active high, sampled at channel 2 slot boundaries |
| duty1_cmd | input | DUTY_W | Channel 1 on-time in clock cycles |
| duty2_cmd | input | DUTY_W | Channel 2 on-time in clock cycles |
| trip_in | input | 2 | Cycle-by-cycle current-sense trip flags, bit 0 channel 1, bit 1 channel 2 |
| ovc_in | input | 2 | Overcurrent fault flags, bit 0 channel 1, bit 1 channel 2 |
| pwm_out | output | 2 | Gate commands, bit 0 channel 1, bit 1 channel 2 |

## Verification
The checker watches every cycle for the properties that hold cycle by cycle:
- the two outputs are never high together;
- neither output is high during discharge;
- an output is high only in its own slot, and the slot flips at each cycle boundary;
- a pulse never exceeds `RAMP_LEN` cycles;
- a rising edge needs a nonzero duty command, and a rising edge on channel 2 needs the enable, both as captured at the boundary;
- both outputs are low one cycle after any overcurrent.

Some behaviour appears only as exact pulse lengths in the bench scenarios:
- that a mid-slot duty change is ignored;
- the blanking window and the trip response;
- the slot length after a sync restart, and that short or held sync pulses are rejected;
- that a fault hold reaches through to the next channel 1 slot.

// File: rtl/dpwm_pkg.sv
package dpwm_pkg;

    localparam int N_CH = 2;

    typedef enum logic {
        SLOT_A = 1'b0,
        SLOT_B = 1'b1
    } slot_e;

    typedef struct packed {
        logic  wrap;      // oscillator cycle ends at this edge
        slot_e slot;      // slot of the current cycle
        slot_e nxt_slot;  // slot that begins after a wrap
        logic  charge;    // ramp in charge phase
    } tb_evt_t;

    function automatic slot_e other_slot(input slot_e s);
        return (s == SLOT_A) ? SLOT_B : SLOT_A;
    endfunction

endpackage

// File: rtl/dpwm_timebase.sv
module dpwm_timebase
    import dpwm_pkg::*;
#(
    parameter int RAMP_LEN  = 20,
    parameter int DISCH_LEN = 4,
    parameter int SYNC_MIN  = 2,
    localparam int PER   = RAMP_LEN + DISCH_LEN,
    localparam int CNT_W = $clog2(PER),
    localparam int RUN_W = $clog2(SYNC_MIN + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             sync_in,
    output logic [CNT_W-1:0] ramp,
    output tb_evt_t          evt
);

    logic [CNT_W-1:0] cnt_q;
    slot_e            slot_q;
    logic             s1_q, s2_q;
    logic [RUN_W-1:0] run_q;
    logic             restart;
    logic             wrap;

    assign restart = s2_q && (run_q == RUN_W'(SYNC_MIN - 1));
    assign wrap    = restart || (cnt_q == CNT_W'(PER - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            s1_q  <= 1'b0;
            s2_q  <= 1'b0;
            run_q <= '0;
        end else begin
            s1_q <= sync_in;
            s2_q <= s1_q;
            if (!s2_q) begin
                run_q <= '0;
            end else if (run_q != RUN_W'(SYNC_MIN)) begin
                run_q <= run_q + RUN_W'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q  <= CNT_W'(PER - 1);
            slot_q <= SLOT_B;
        end else if (wrap) begin
            cnt_q  <= '0;
            slot_q <= other_slot(slot_q);
        end else begin
            cnt_q  <= cnt_q + CNT_W'(1);
        end
    end

    assign ramp         = cnt_q;
    assign evt.wrap     = wrap;
    assign evt.slot     = slot_q;
    assign evt.nxt_slot = other_slot(slot_q);
    assign evt.charge   = (cnt_q < CNT_W'(RAMP_LEN));

endmodule

// File: rtl/dpwm_fault.sv
module dpwm_fault
    import dpwm_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic [N_CH-1:0] ovc_in,
    input  tb_evt_t         evt,
    output logic            hold_nxt
);

    logic hold_q;

    always_comb begin
        if (|ovc_in) begin
            hold_nxt = 1'b1;
        end else if (evt.wrap && evt.nxt_slot == SLOT_A) begin
            hold_nxt = 1'b0;
        end else begin
            hold_nxt = hold_q;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_q <= 1'b0;
        end else begin
            hold_q <= hold_nxt;
        end
    end

endmodule

// File: rtl/dpwm_channel.sv
module dpwm_channel
    import dpwm_pkg::*;
#(
    parameter slot_e CH        = SLOT_A,
    parameter int    CNT_W     = 5,
    parameter int    DUTY_W    = 5,
    parameter int    BLANK_CYC = 3,
    localparam int   BLK_W     = $clog2(BLANK_CYC + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  tb_evt_t           evt,
    input  logic [CNT_W-1:0]  ramp,
    input  logic [DUTY_W-1:0] duty_cmd,
    input  logic              en,
    input  logic              trip,
    input  logic              hold_nxt,
    output logic              pwm
);

    logic              active_q;
    logic [DUTY_W-1:0] duty_q;
    logic [BLK_W-1:0]  blank_q;
    logic              blank_done;
    logic              trip_hit;

    assign blank_done = (blank_q >= BLK_W'(BLANK_CYC));
    assign trip_hit   = trip && pwm && blank_done;
    assign pwm        = active_q && evt.charge && (evt.slot == CH)
                        && (ramp < CNT_W'(duty_q));

    always_ff @(posedge clk) begin
        if (rst) begin
            active_q <= 1'b0;
            duty_q   <= '0;
            blank_q  <= '0;
        end else if (evt.wrap) begin
            blank_q <= '0;
            if (evt.nxt_slot == CH) begin
                duty_q   <= duty_cmd;
                active_q <= en && !hold_nxt;
            end else begin
                active_q <= 1'b0;
            end
        end else begin
            if (hold_nxt || trip_hit) begin
                active_q <= 1'b0;
            end
            if (pwm && !blank_done) begin
                blank_q <= blank_q + BLK_W'(1);
            end
        end
    end

endmodule

// File: rtl/dual_pwm_ctrl.sv
module dual_pwm_ctrl
    import dpwm_pkg::*;
#(
    parameter int RAMP_LEN  = 20,
    parameter int DISCH_LEN = 4,
    parameter int BLANK_CYC = 3,
    parameter int SYNC_MIN  = 2,
    localparam int DUTY_W = $clog2(RAMP_LEN + 1),
    localparam int CNT_W  = $clog2(RAMP_LEN + DISCH_LEN)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sync_in,
    input  logic              ch2_en,
    input  logic [DUTY_W-1:0] duty1_cmd,
    input  logic [DUTY_W-1:0] duty2_cmd,
    input  logic [N_CH-1:0]   trip_in,
    input  logic [N_CH-1:0]   ovc_in,
    output logic [N_CH-1:0]   pwm_out
);

    tb_evt_t           tb_evt;
    logic [CNT_W-1:0]  ramp;
    logic              hold_nxt;
    logic [DUTY_W-1:0] duty_arr [N_CH];
    logic [N_CH-1:0]   en_arr;

    assign duty_arr[0] = duty1_cmd;
    assign duty_arr[1] = duty2_cmd;
    assign en_arr      = {ch2_en, 1'b1};

    dpwm_timebase #(
        .RAMP_LEN (RAMP_LEN),
        .DISCH_LEN(DISCH_LEN),
        .SYNC_MIN (SYNC_MIN)
    ) tbase_i (
        .clk    (clk),
        .rst    (rst),
        .sync_in(sync_in),
        .ramp   (ramp),
        .evt    (tb_evt)
    );

    dpwm_fault fault_i (
        .clk     (clk),
        .rst     (rst),
        .ovc_in  (ovc_in),
        .evt     (tb_evt),
        .hold_nxt(hold_nxt)
    );

    for (genvar g = 0; g < N_CH; g++) begin : g_ch
        dpwm_channel #(
            .CH       (slot_e'(1'(g))),
            .CNT_W    (CNT_W),
            .DUTY_W   (DUTY_W),
            .BLANK_CYC(BLANK_CYC)
        ) ch_i (
            .clk     (clk),
            .rst     (rst),
            .evt     (tb_evt),
            .ramp    (ramp),
            .duty_cmd(duty_arr[g]),
            .en      (en_arr[g]),
            .trip    (trip_in[g]),
            .hold_nxt(hold_nxt),
            .pwm     (pwm_out[g])
        );
    end

endmodule

// File: rtl/dpwm_ctrl_chk.sv
module dpwm_ctrl_chk
    import dpwm_pkg::*;
#(
    parameter int RAMP_LEN = 20,
    parameter int DUTY_W   = 5,
    localparam int RUN_W   = $clog2(RAMP_LEN + 2)
) (
    input logic              clk,
    input logic              rst,
    input logic [N_CH-1:0]   pwm_out,
    input logic              ch2_en,
    input logic [DUTY_W-1:0] duty1_cmd,
    input logic [DUTY_W-1:0] duty2_cmd,
    input logic [N_CH-1:0]   ovc_in,
    input tb_evt_t           evt
);

    logic [RUN_W-1:0] run_a, run_b;

    always_ff @(posedge clk) begin
        if (rst) begin
            run_a <= '0;
            run_b <= '0;
        end else begin
            run_a <= pwm_out[0] ? ((run_a == RUN_W'(RAMP_LEN + 1)) ? run_a : run_a + RUN_W'(1)) : '0;
            run_b <= pwm_out[1] ? ((run_b == RUN_W'(RAMP_LEN + 1)) ? run_b : run_b + RUN_W'(1)) : '0;
        end
    end

    AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (rst) $onehot0(pwm_out)); // R1
    AST_SLOT_A_ONLY: assert property (@(posedge clk) disable iff (rst) pwm_out[0] |-> evt.slot == SLOT_A); // R1
    AST_SLOT_B_ONLY: assert property (@(posedge clk) disable iff (rst) pwm_out[1] |-> evt.slot == SLOT_B); // R1
    AST_SLOT_TOGGLE: assert property (@(posedge clk) disable iff (rst) evt.wrap |=> evt.slot != $past(evt.slot)); // R1
    AST_MAX_ON_A: assert property (@(posedge clk) disable iff (rst) run_a <= RUN_W'(RAMP_LEN)); // R3
    AST_MAX_ON_B: assert property (@(posedge clk) disable iff (rst) run_b <= RUN_W'(RAMP_LEN)); // R3
    AST_DISCH_LOW: assert property (@(posedge clk) disable iff (rst) !evt.charge |-> pwm_out == 2'b00); // R4
    AST_ZERO_DUTY_A: assert property (@(posedge clk) disable iff (rst) $rose(pwm_out[0]) |-> $past(duty1_cmd) != '0); // R5
    AST_ZERO_DUTY_B: assert property (@(posedge clk) disable iff (rst) $rose(pwm_out[1]) |-> $past(duty2_cmd) != '0); // R5
    AST_CH2_ENABLE: assert property (@(posedge clk) disable iff (rst) $rose(pwm_out[1]) |-> $past(ch2_en)); // R8
    AST_FAULT_OFF: assert property (@(posedge clk) disable iff (rst) (|ovc_in) |=> pwm_out == 2'b00); // R10

endmodule

bind dual_pwm_ctrl dpwm_ctrl_chk #(
    .RAMP_LEN(RAMP_LEN),
    .DUTY_W  (DUTY_W)
) chk_i (
    .clk      (clk),
    .rst      (rst),
    .pwm_out  (pwm_out),
    .ch2_en   (ch2_en),
    .duty1_cmd(duty1_cmd),
    .duty2_cmd(duty2_cmd),
    .ovc_in   (ovc_in),
    .evt      (tb_evt)
);

// File: tb/dual_pwm_ctrl_tb_top.sv
`timescale 1ns/1ps
module dual_pwm_ctrl_tb_top;

    localparam int RAMP_LEN  = 20;
    localparam int DISCH_LEN = 4;
    localparam int BLANK_CYC = 3;
    localparam int SYNC_MIN  = 2;
    localparam int PER       = RAMP_LEN + DISCH_LEN;
    localparam int DW        = $clog2(RAMP_LEN + 1);

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          sync_in = 1'b0;
    logic          ch2_en = 1'b1;
    logic [DW-1:0] duty1 = '0;
    logic [DW-1:0] duty2 = '0;
    logic [1:0]    trip_in = 2'b00;
    logic [1:0]    ovc_in = 2'b00;
    logic [1:0]    pwm_out;

    int checks = 0;
    int fails  = 0;
    int sync_left = 0;
    bit finished = 1'b0;

    logic [1:0] q_exp [$];
    string      q_tag [$];

    always #10 clk = ~clk;

    dual_pwm_ctrl #(
        .RAMP_LEN (RAMP_LEN),
        .DISCH_LEN(DISCH_LEN),
        .BLANK_CYC(BLANK_CYC),
        .SYNC_MIN (SYNC_MIN)
    ) dut_i (
        .clk      (clk),
        .rst      (rst),
        .sync_in  (sync_in),
        .ch2_en   (ch2_en),
        .duty1_cmd(duty1),
        .duty2_cmd(duty2),
        .trip_in  (trip_in),
        .ovc_in   (ovc_in),
        .pwm_out  (pwm_out)
    );

    // monitor: pops one expected value per cycle, mid-cycle
    always @(negedge clk) begin
        if (q_exp.size() != 0) begin
            logic [1:0] e;
            string t;
            e = q_exp.pop_front();
            t = q_tag.pop_front();
            checks++;
            if (pwm_out !== e) begin
                fails++;
                $display("FAIL %s: pwm_out=%b expected=%b", t, pwm_out, e);
            end
        end
    end

    // driver: one slot; output of channel id expected high in cycles 0..exp_on-1
    task automatic run_slot(input int id, input int len, input int exp_on,
                            input int trip_c, input int ovc_c,
                            input int sync_c, input int sync_w,
                            input int chg_c, input int chg_val, input string tag);
        for (int c = 0; c < len; c++) begin
            @(posedge clk); #1;
            trip_in = (c == trip_c) ? 2'(1 << id) : 2'b00;
            ovc_in  = (c == ovc_c)  ? 2'(1 << id) : 2'b00;
            if (c == sync_c) sync_left = sync_w;
            sync_in = (sync_left > 0);
            if (sync_left > 0) sync_left--;
            if (c == chg_c) begin
                if (id == 0) duty1 = DW'(chg_val);
                else         duty2 = DW'(chg_val);
            end
            q_exp.push_back((c < exp_on) ? 2'(1 << id) : 2'b00);
            q_tag.push_back(tag);
        end
    endtask

    task automatic plain(input int id, input int exp_on, input string tag);
        run_slot(id, PER, exp_on, -1, -1, -1, 0, -1, 0, tag);
    endtask

    initial begin
        #(200000 * 20);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog: run did not complete, actual=hung expected=done");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        duty1 = DW'(8);
        duty2 = DW'(12);
        // R11: outputs low during reset
        repeat (4) begin
            @(posedge clk); #1;
            q_exp.push_back(2'b00);
            q_tag.push_back("R11 reset");
        end
        rst = 1'b0;
        plain(0, 8, "R11 R2 first slot");
        plain(1, 12, "R1 second slot channel 2");
        duty1 = DW'(25);
        plain(0, 20, "R3 R4 saturate ch1");
        duty2 = DW'(20);
        plain(1, 20, "R3 R4 full ch2");
        duty1 = '0;
        plain(0, 0, "R5 zero duty");
        duty2 = DW'(5);
        ch2_en = 1'b0;
        plain(1, 0, "R8 ch2 disabled");
        ch2_en = 1'b1;
        duty1 = DW'(10);
        run_slot(0, PER, 10, -1, -1, -1, 0, 3, 2, "R2 mid-slot change ignored");
        plain(1, 5, "R8 ch2 re-enabled");
        plain(0, 2, "R2 new command next slot");
        duty2 = DW'(15);
        run_slot(1, PER, 4, 3, -1, -1, 0, -1, 0, "R6 trip after blanking");
        duty1 = DW'(12);
        run_slot(0, PER, 12, 2, -1, -1, 0, -1, 0, "R7 trip in blank ch1");
        run_slot(1, PER, 15, 1, -1, -1, 0, -1, 0, "R7 trip in blank ch2");
        run_slot(0, PER, 8, 7, -1, -1, 0, -1, 0, "R6 trip mid pulse");
        plain(1, 15, "R6 recovers");
        // R10 fault restart
        run_slot(0, PER, 5, -1, 4, -1, 0, -1, 0, "R10 fault in ch1 slot");
        plain(1, 0, "R10 ch2 held");
        plain(0, 12, "R10 ch1 restart");
        run_slot(1, PER, 15, -1, 23, -1, 0, -1, 0, "R10 fault at boundary");
        plain(0, 0, "R10 ch1 held after boundary fault");
        plain(1, 0, "R10 ch2 held after boundary fault");
        plain(0, 12, "R10 restart after boundary fault");
        plain(1, 15, "R10 normal ch2");
        run_slot(0, PER, 12, -1, 21, -1, 0, -1, 0, "R10 fault in discharge");
        plain(1, 0, "R10 ch2 held after discharge fault");
        plain(0, 12, "R10 restart after discharge fault");
        plain(1, 15, "R10 normal");
        // R9 sync restart
        run_slot(0, 2 + SYNC_MIN + 2, 12, -1, -1, 2, SYNC_MIN, -1, 0, "R9 sync truncates slot");
        plain(1, 15, "R9 next slot full");
        run_slot(0, PER, 12, -1, -1, 2, 1, -1, 0, "R9 short pulse ignored");
        plain(1, 15, "R9 after short pulse");
        run_slot(0, 4 + SYNC_MIN + 2, 12, -1, -1, 4, 8, -1, 0, "R9 held pulse one restart");
        plain(1, 15, "R9 no retrigger");
        plain(0, 12, "R9 steady");
        @(posedge clk);
        @(negedge clk);
        @(negedge clk);
        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule